// File: doc/BRIEF.md
# Interrupt Queue Status Tracker

This block turns per-channel transfer events into 32-bit interrupt descriptors and stores them, one dword per entry, in a circular interrupt queue held in shared memory, using a simple single-cycle memory write port. Each event strobe carries a direction, a group number, a channel number, end-of-buffer and end-of-message flags, an event code for other conditions and a byte length. A receive event flagged as both end-of-buffer and end-of-message yields one descriptor. A transmit event with both flags yields two descriptors.

The block also holds the status word that the host reads before it services interrupts. The word has three fields. The service index is owned by the host. The interrupt count covers the descriptors written since the last read and clears when the word is read. The full flag is sticky until a read. While the queue is full, descriptors wait in a small internal FIFO. An event whose descriptors do not fit in that FIFO is discarded. A configuration write moves the queue base or changes its size, and it restarts the queue and the status word.

Top module: `irq_queue_tracker`

## Requirements
- R1: A pulse on `reg_rd` loads `reg_rdata` on the next clock edge with bit 31 = 0, bits 30:16 = service index, bit 15 = full flag and bits 14:0 = interrupt count. The values are those held before that edge.
- R2: The service index changes only when `reg_wr` is pulsed, and it then takes `reg_wdata[30:16]`. The block never advances it. Bits 15:0 of `reg_wdata` have no effect on the count or the full flag.
- R3: The count is the number of descriptor writes (`mem_we` cycles) since the last status read. A read in the same cycle as a write returns the count without that write, and the write is counted for the following read.
- R4: The count saturates at 32767 and does not wrap.
- R5: The full flag is set by a write that leaves the queue full, which is the case when the next write position equals the service index. The flag stays set until a status read clears it.
- R6: While the queue is full, no write occurs. Up to 8 descriptors are held and are written in arrival order once the host moves the service index.
- R7: `mem_addr` equals the queue base plus the write position. The position runs 0 to size-1 and then wraps to 0. The size must be at least 2.
- R8: A receive event with end-of-buffer and/or end-of-message set produces one descriptor carrying `ev_len`. Its code is 2 (end-of-message) if `ev_eom` is set, otherwise 1 (end-of-buffer). A transmit event with only one of the flags set produces one descriptor with the matching code (1 for end-of-buffer, 2 for end-of-message) and carries `ev_len`.
- R9: A transmit event with both flags produces two descriptors in order: code 1, then code 2. Both carry `ev_len`.
- R10: An event with neither flag produces one descriptor with code `ev_code` and length 0.
- R11: The descriptor layout is bit 31 = direction (1 = transmit), bits 30:29 = group[1:0], bits 28:24 = channel, bits 23:20 = code, bits 19:15 = 0, bit 14 = group[2], bits 13:0 = length.
- R12: `cfg_wr` loads the base and size and clears the service index, count, full flag and write position. `soft_rst` clears the same state and also empties the held descriptors. `rst` does all of this and restores the default base and size.
- R13: An event whose descriptors exceed the free FIFO space is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous soft reset |
| ev_valid | input | 1 | Event strobe |
| ev_tx | input | 1 | Direction, 1 = transmit |
| ev_eob | input | 1 | End-of-buffer flag |
| ev_eom | input | 1 | End-of-message flag |
| ev_code | input | 4 | Code for events with neither flag |
| ev_group | input | 3 | Group number |
| ev_chan | input | 5 | Channel number |
| ev_len | input | 14 | Byte length |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 32 | Status write data |
| reg_rdata | output | 32 | Status read data |
| cfg_wr | input | 1 | Queue configuration write |
| cfg_base | input | AW | New queue base (dword address) |
| cfg_size | input | 15 | New queue size in entries |
| mem_we | output | 1 | Descriptor write strobe |
| mem_addr | output | AW | Descriptor dword address |
| mem_wdata | output | 32 | Descriptor word |

## Verification
Two functions can fall in the same cycle: a status read that clears the count, and a descriptor write that increments it. The bench watches `mem_we` and raises `reg_rd` during a write cycle. It then expects that read to return the old count and the next read to return exactly 1. A second coincidence comes from the host changing the service index while descriptors are waiting. This is judged by the order and addresses of the writes that resume.

// File: rtl/irq_q_pkg.sv
package irq_q_pkg;
  localparam int IDX_W  = 15;
  localparam int CODE_W = 4;
  localparam int GRP_W  = 3;
  localparam int CHAN_W = 5;
  localparam int LEN_W  = 14;
  localparam int DESC_W = 32;
  localparam logic [IDX_W-1:0]  CNT_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_EOB = 4'h1;
  localparam logic [CODE_W-1:0] CODE_EOM = 4'h2;

  typedef logic [DESC_W-1:0] desc_t;

  function automatic desc_t pack_desc(input logic tx, input logic [GRP_W-1:0] grp,
                                      input logic [CHAN_W-1:0] chan,
                                      input logic [CODE_W-1:0] code,
                                      input logic [LEN_W-1:0] len);
    return {tx, grp[1:0], chan, code, 5'b0, grp[2], len};
  endfunction
endpackage

// File: rtl/irq_desc_build.sv
module irq_desc_build
  import irq_q_pkg::*;
(
  input  logic              ev_valid,
  input  logic              ev_tx,
  input  logic              ev_eob,
  input  logic              ev_eom,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [GRP_W-1:0]  ev_group,
  input  logic [CHAN_W-1:0] ev_chan,
  input  logic [LEN_W-1:0]  ev_len,
  output logic [1:0]        n_desc,
  output desc_t             desc0,
  output desc_t             desc1
);
  logic split_tx;
  logic [CODE_W-1:0] code0;
  logic [LEN_W-1:0]  len0;

  assign split_tx = ev_tx && ev_eob && ev_eom;

  always_comb begin
    if (split_tx)              code0 = CODE_EOB;
    else if (ev_eom)           code0 = CODE_EOM;
    else if (ev_eob)           code0 = CODE_EOB;
    else                       code0 = ev_code;
    len0 = (ev_eob || ev_eom) ? ev_len : '0;
  end

  assign desc0  = pack_desc(ev_tx, ev_group, ev_chan, code0, len0);
  assign desc1  = pack_desc(ev_tx, ev_group, ev_chan, CODE_EOM, ev_len);
  assign n_desc = !ev_valid ? 2'd0 : (split_tx ? 2'd2 : 2'd1);
endmodule

// File: rtl/irq_desc_fifo.sv
module irq_desc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [1:0]   wr_n,
  input  logic [W-1:0] wr_d0,
  input  logic [W-1:0] wr_d1,
  input  logic         rd_en,
  output logic [W-1:0] rd_d,
  output logic         empty,
  output logic [$clog2(DEPTH+1)-1:0] free
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) mem[wp] <= wr_d0;
    if (wr_n == 2'd2) mem[wp + PW'(1)] <= wr_d1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + PW'(wr_n);
      rp  <= rp + PW'(rd_en);
      cnt <= cnt + CW'(wr_n) - CW'(rd_en);
    end
  end

  assign rd_d  = mem[rp];
  assign empty = (cnt == '0);
  assign free  = CW'(DEPTH) - cnt;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_q_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rd,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_svc,
  input  logic             push,
  input  logic             push_fills,
  output logic [IDX_W-1:0] svc,
  output logic [IDX_W-1:0] cnt,
  output logic             full,
  output logic [31:0]      rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      svc   <= '0;
      cnt   <= '0;
      full  <= 1'b0;
      rdata <= '0;
    end else if (clr) begin
      svc  <= '0;
      cnt  <= '0;
      full <= 1'b0;
      if (rd) rdata <= '0;
    end else begin
      if (rd) rdata <= {1'b0, svc, full, cnt};
      if (wr) svc <= wr_svc;
      if (rd)
        cnt <= push ? IDX_W'(1) : '0;
      else if (push && cnt != CNT_MAX)
        cnt <= cnt + IDX_W'(1);
      if (rd)
        full <= push && push_fills;
      else if (push && push_fills)
        full <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_queue_tracker.sv
module irq_queue_tracker
  import irq_q_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FIFO_DEPTH = 8,
  parameter logic [AW-1:0]    DEF_BASE = '0,
  parameter logic [14:0]      DEF_SIZE = 15'd16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ev_valid,
  input  logic              ev_tx,
  input  logic              ev_eob,
  input  logic              ev_eom,
  input  logic [3:0]        ev_code,
  input  logic [2:0]        ev_group,
  input  logic [4:0]        ev_chan,
  input  logic [13:0]       ev_len,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_base,
  input  logic [14:0]       cfg_size,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int FCW = $clog2(FIFO_DEPTH+1);

  logic [1:0]       n_desc, wr_n;
  desc_t            d0, d1, head;
  logic             f_empty, issue, q_full, stat_clr;
  logic [FCW-1:0]   f_free;
  logic [AW-1:0]    base_q;
  logic [IDX_W-1:0] size_q, wr_pos, nxt_pos, svc_idx, int_cnt;
  logic             full_flag;

  irq_desc_build u_build (
    .ev_valid(ev_valid), .ev_tx(ev_tx), .ev_eob(ev_eob), .ev_eom(ev_eom),
    .ev_code(ev_code), .ev_group(ev_group), .ev_chan(ev_chan), .ev_len(ev_len),
    .n_desc(n_desc), .desc0(d0), .desc1(d1)
  );

  // whole event is admitted or dropped
  assign wr_n = (FCW'(n_desc) <= f_free) ? n_desc : 2'd0;

  irq_desc_fifo #(.DEPTH(FIFO_DEPTH), .W(DESC_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(soft_rst), .wr_n(wr_n), .wr_d0(d0), .wr_d1(d1),
    .rd_en(issue), .rd_d(head), .empty(f_empty), .free(f_free)
  );

  assign stat_clr = soft_rst || cfg_wr;
  assign nxt_pos  = (wr_pos == size_q - IDX_W'(1)) ? '0 : wr_pos + IDX_W'(1);
  assign q_full   = (nxt_pos == svc_idx);
  assign issue    = !f_empty && !q_full && !stat_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= DEF_BASE;
      size_q <= DEF_SIZE;
    end else if (cfg_wr) begin
      base_q <= cfg_base;
      size_q <= cfg_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stat_clr) wr_pos <= '0;
    else if (issue)      wr_pos <= nxt_pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= issue;
      if (issue) begin
        mem_addr  <= base_q + AW'(wr_pos);
        mem_wdata <= head;
      end
    end
  end

  irq_status_reg u_stat (
    .clk(clk), .rst(rst), .clr(stat_clr), .rd(reg_rd), .wr(reg_wr),
    .wr_svc(reg_wdata[30:16]), .push(mem_we), .push_fills(q_full),
    .svc(svc_idx), .cnt(int_cnt), .full(full_flag), .rdata(reg_rdata)
  );
endmodule

// File: rtl/irq_queue_checker.sv
module irq_queue_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic          cfg_wr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   reg_rdata,
  input logic [14:0]   svc,
  input logic [14:0]   cnt,
  input logic          full,
  input logic [AW-1:0] base_q,
  input logic [14:0]   size_q
);
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[31] == 1'b0);

  assert_svc_host_only_R2: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !cfg_wr && !soft_rst) |=> $stable(svc));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !reg_rd && !cfg_wr && !soft_rst && cnt != 15'h7FFF)
      |=> cnt == $past(cnt) + 15'd1);

  assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == 15'h7FFF && !reg_rd && !cfg_wr && !soft_rst) |=> cnt == 15'h7FFF);

  assert_full_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(mem_we));

  assert_addr_in_queue_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_addr - base_q) < AW'(size_q)));
endmodule

bind irq_queue_tracker irq_queue_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .mem_we(mem_we), .mem_addr(mem_addr),
  .reg_rdata(reg_rdata), .svc(svc_idx), .cnt(int_cnt), .full(full_flag),
  .base_q(base_q), .size_q(size_q)
);

// File: tb/tb_irq_queue_tracker.sv
module tb_irq_queue_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0;
  logic ev_valid = 0, ev_tx = 0, ev_eob = 0, ev_eom = 0;
  logic [3:0] ev_code = 0;
  logic [2:0] ev_group = 0;
  logic [4:0] ev_chan = 0;
  logic [13:0] ev_len = 0;
  logic reg_rd = 0, reg_wr = 0, cfg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [31:0] cfg_base = 0;
  logic [14:0] cfg_size = 0;
  logic mem_we;
  logic [31:0] mem_addr, mem_wdata;

  always #10 clk = ~clk;  // 50 MHz

  irq_queue_tracker dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ev_valid(ev_valid), .ev_tx(ev_tx),
    .ev_eob(ev_eob), .ev_eom(ev_eom), .ev_code(ev_code), .ev_group(ev_group),
    .ev_chan(ev_chan), .ev_len(ev_len), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_wr(cfg_wr),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  typedef struct packed {
    logic tx, eob, eom;
    logic [3:0] code;
    logic [2:0] grp;
    logic [4:0] chan;
    logic [13:0] len;
    logic [1:0] n;
    logic [31:0] w0, w1;
  } vec_t;

  // expected words follow the R11 layout
  localparam vec_t VECS [7] = '{
    '{1'b0,1'b1,1'b0,4'h0,3'b101,5'd7, 14'd100, 2'd1,32'h2710_4064,32'h0},         // R8 rx eob
    '{1'b0,1'b1,1'b1,4'h0,3'b010,5'd31,14'h3FFF,2'd1,32'h5F20_3FFF,32'h0},         // R8 rx merged
    '{1'b1,1'b1,1'b1,4'h0,3'b111,5'd3, 14'h0200,2'd2,32'hE310_4200,32'hE320_4200}, // R9 tx split
    '{1'b1,1'b1,1'b0,4'h0,3'b000,5'd0, 14'd5,   2'd1,32'h8010_0005,32'h0},         // R8 tx eob
    '{1'b0,1'b0,1'b0,4'h9,3'b100,5'd2, 14'h123, 2'd1,32'h0290_4000,32'h0},         // R10 rx other
    '{1'b1,1'b0,1'b0,4'hC,3'b011,5'd16,14'd77,  2'd1,32'hF0C0_0000,32'h0},         // R10 tx other
    '{1'b0,1'b0,1'b1,4'h0,3'b000,5'd1, 14'd9,   2'd1,32'h0120_0009,32'h0}          // R8 rx eom
  };

  int n_chk = 0, n_fail = 0, cyc = 0, wcount = 0, log_n = 0;
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  logic [31:0] last_a;

  always @(negedge clk) begin
    if (mem_we) begin
      wcount = wcount + 1;
      last_a = mem_addr;
      if (log_n < 64) begin
        log_a[log_n] = mem_addr;
        log_d[log_n] = mem_wdata;
        log_n = log_n + 1;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog got %0d cycles exp fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd_status(output logic [31:0] v);
    @(negedge clk) reg_rd = 1'b1;
    @(negedge clk) reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wr_svc(input logic [14:0] s);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = {1'b0, s, 16'h0000}; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic set_ev(input logic tx, eob, eom, input logic [3:0] code,
                        input logic [2:0] grp, input logic [4:0] chan, input logic [13:0] len);
    ev_tx = tx; ev_eob = eob; ev_eom = eom; ev_code = code;
    ev_group = grp; ev_chan = chan; ev_len = len;
  endtask

  task automatic pulse_ev(input logic tx, eob, eom, input logic [13:0] len);
    @(negedge clk) begin set_ev(tx, eob, eom, 4'h5, 3'b000, 5'd0, len); ev_valid = 1'b1; end
    @(negedge clk) ev_valid = 1'b0;
  endtask

  task automatic stream(input int n);
    @(negedge clk) begin set_ev(1'b0, 1'b0, 1'b0, 4'h7, 3'b000, 5'd0, 14'd0); ev_valid = 1'b1; end
    repeat (n) @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int pos, w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    chk("R12 reset status", reg_rdata, 32'h0);
    chk("R12 reset no write", {31'b0, mem_we}, 32'h0);
    rd_status(v);
    chk("R12 reset read", v, 32'h0);

    @(negedge clk) begin cfg_wr = 1'b1; cfg_base = 32'h1000; cfg_size = 15'd16; end
    @(negedge clk) cfg_wr = 1'b0;

    // table walk: R8 R9 R10 R11 R7
    pos = 0;
    foreach (VECS[i]) begin
      log_n = 0;
      @(negedge clk) begin
        set_ev(VECS[i].tx, VECS[i].eob, VECS[i].eom, VECS[i].code,
               VECS[i].grp, VECS[i].chan, VECS[i].len);
        ev_valid = 1'b1;
      end
      @(negedge clk) ev_valid = 1'b0;
      idle(6);
      chk("R9 descriptor count", log_n, {30'b0, VECS[i].n});
      chk("R11 word0", log_d[0], VECS[i].w0);
      chk("R7 addr0", log_a[0], 32'h1000 + pos);
      pos = pos + 1;
      if (VECS[i].n == 2'd2) begin
        chk("R9 word1", log_d[1], VECS[i].w1);
        chk("R7 addr1", log_a[1], 32'h1000 + pos);
        pos = pos + 1;
      end
    end

    rd_status(v);
    chk("R1 R3 count after table", v, 32'h0000_0008);
    rd_status(v);
    chk("R3 count cleared by read", v, 32'h0);

    // R2: host write of service index, low bits ignored
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF & {1'b1, 15'd5, 1'b1, 15'h7FFF}; end
    @(negedge clk) reg_wr = 1'b0;
    rd_status(v);
    chk("R2 svc written low bits ignored", v, 32'h0005_0000);

    // R5 R6 R7: fill with wrap, hold the rest
    log_n = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk) begin set_ev(1'b0, 1'b1, 1'b0, 4'h0, 3'b000, 5'd0, 14'(k)); ev_valid = 1'b1; end
    end
    @(negedge clk) ev_valid = 1'b0;
    idle(12);
    chk("R6 writes until full", log_n, 32'd12);
    chk("R7 wrap to offset 0", log_a[8], 32'h1000);
    chk("R7 last before full", log_a[11], 32'h1003);
    rd_status(v);
    chk("R5 full and count", v, 32'h0005_800C);
    rd_status(v);
    chk("R5 full cleared by read", v, 32'h0005_0000);
    log_n = 0;
    wr_svc(15'd7);
    idle(8);
    chk("R6 held drained count", log_n, 32'd2);
    chk("R6 held order first", log_d[0], 32'h0010_000C);
    chk("R6 held order second", log_d[1], 32'h0010_000D);
    chk("R6 resumed addr", log_a[0], 32'h1004);
    rd_status(v);
    chk("R5 full again", v, 32'h0007_8002);

    // R13: fill FIFO while queue full, then overflow event dropped
    log_n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) begin set_ev(1'b1, 1'b1, 1'b1, 4'h0, 3'b000, 5'd0, 14'(16 + k)); ev_valid = 1'b1; end
    end
    @(negedge clk) begin set_ev(1'b0, 1'b1, 1'b0, 4'h0, 3'b000, 5'd0, 14'h3F); end
    @(negedge clk) ev_valid = 1'b0;
    idle(4);
    chk("R6 no write while full", log_n, 32'd0);
    wr_svc(15'd6);
    idle(14);
    chk("R13 overflow dropped", log_n, 32'd8);
    w0 = 0;
    for (int k = 0; k < 8; k++)
      if (log_d[k] !== ({((k % 2) == 0) ? 32'h8010_0000 : 32'h8020_0000} | (32'd16 + k / 2)))
        w0 = w0 + 1;
    chk("R9 R13 held tx words", w0, 32'd0);
    rd_status(v);
    chk("R5 no full without fill", v, 32'h0006_0008);

    // R3: read in the same cycle as a write
    pulse_ev(1'b0, 1'b1, 1'b0, 14'd1);
    while (!mem_we) @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk) reg_rd = 1'b0;
    chk("R3 same-cycle read old count", reg_rdata, 32'h0006_0000);
    rd_status(v);
    chk("R3 same-cycle write kept", v, 32'h0006_0001);

    // R12: configuration write clears status
    pulse_ev(1'b0, 1'b1, 1'b0, 14'd2);
    idle(5);
    @(negedge clk) begin cfg_wr = 1'b1; cfg_base = 32'h0; cfg_size = 15'd32767; end
    @(negedge clk) cfg_wr = 1'b0;
    rd_status(v);
    chk("R12 cfg clears status", v, 32'h0);

    // R4: saturation
    w0 = wcount;
    stream(32766);
    idle(10);
    chk("R7 writes to full large queue", wcount - w0, 32'd32766);
    chk("R7 last position large queue", last_a, 32'd32765);
    wr_svc(15'd16000);
    stream(17000);
    idle(20);
    chk("R6 writes after svc move", wcount - w0, 32'd48766);
    rd_status(v);
    chk("R4 count saturated", v, 32'h3E80_FFFF);

    // R12: soft reset clears status and held descriptors
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    w0 = wcount;
    idle(12);
    chk("R12 soft reset drops held", wcount - w0, 32'd0);
    rd_status(v);
    chk("R12 soft reset status", v, 32'h0);

    summary();
    $finish;
  end
endmodule